// File: doc/BRIEF.md
# Dual-Port Audio Master Clock Generator

This block produces the frame clock (LRCK) and the bit clock (SCLK) for two audio serial ports that run as clock masters. The block runs on one system clock. Each master clock source arrives as a one-cycle enable tick on that clock, not as a real clock edge. Each port picks one of the sources. A two-bit code then sets a pre-divider of 1, 1.5, 2 or 3, which turns the source ticks into the port's internal master ticks. A speed bit selects the final ratios. Single speed gives a frame of 256 internal ticks with a bit clock every 4 internal ticks. Double speed gives 128 and 2.

Each port is driven only while the global enable and that port's master bit are both set. Otherwise its output-enable is low and its clocks rest low. When any setting of a port changes, that port's dividers restart, so the next frame begins with LRCK low, on the left channel.

Top module: `audio_master_clkgen`

## Requirements
- R1: The frequency code per port (bits 2p+1:2p of `port_freq`) divides the selected source tick rate as follows: 00 by 1, 01 by 1.5 (internal ticks after alternately 2 and 1 source ticks), 10 by 2, 11 by 3.
- R2: The LRCK period is 256 internal ticks when the speed bit is 0 and 128 when it is 1.
- R3: The SCLK period is 4 internal ticks in single speed and 2 in double speed, so each LRCK period contains exactly 64 SCLK rising edges.
- R4: Each port takes its source from its own select field (bits p of `port_src_sel`, value s picks `src_tick[s]`) and is unaffected by the other port's settings.
- R5: `clk_oe[p]` is high one cycle after `master_en` and `port_master[p]` are both high, and low one cycle after either is low; while `clk_oe[p]` is low, `lrck[p]` and `sclk[p]` are low.
- R6: LRCK and SCLK of a port change only in the cycle after a tick of its selected source, unless the port was reconfigured or disabled.
- R7: LRCK changes only together with a falling SCLK edge and is high for exactly half of each period.
- R8: A change of a port's select, frequency code or speed bit drives that port's LRCK and SCLK low in the next cycle and restarts its frame.
- R9: After reset every LRCK, SCLK and output-enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_en | input | 1 | Global enable for all master ports |
| src_tick | input | NUM_SRC | One-cycle ticks, one per master clock source |
| port_master | input | NUM_PORTS | Per-port master-mode bit |
| port_src_sel | input | NUM_PORTS*SEL_W | Per-port source index |
| port_freq | input | 2*NUM_PORTS | Per-port pre-divider code |
| port_speed | input | NUM_PORTS | Per-port speed bit, 1 = double speed |
| lrck | output | NUM_PORTS | Frame clock per port |
| sclk | output | NUM_PORTS | Bit clock per port |
| clk_oe | output | NUM_PORTS | Output-enable for the clock pins of each port |

## Verification
The assertions assume that each source tick lasts one system cycle and that the settings are changed only at system clock edges. They also assume the index in a select field names an existing source. The bench drives every source as a periodic tick with a period of 1 to 3 cycles chosen from a seeded generator. It keeps each select field within the source count. It applies setting changes one cycle apart so that every restart is seen on its own.

// File: rtl/acg_pkg.sv
package acg_pkg;

   typedef enum logic [1:0] {
      PDIV_1   = 2'b00,
      PDIV_1P5 = 2'b01,
      PDIV_2   = 2'b10,
      PDIV_3   = 2'b11
   } prediv_e;

   // last value of the source-tick phase counter for each pre-divide mode
   function automatic logic [1:0] prediv_last(prediv_e m);
      case (m)
         PDIV_1:  return 2'd0;
         PDIV_2:  return 2'd1;
         default: return 2'd2;
      endcase
   endfunction

endpackage

// File: rtl/acg_prediv.sv
module acg_prediv
   import acg_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    clear,
   input  logic    tick_in,
   input  prediv_e mode,
   output logic    tick_out
);

   logic [1:0] phase;

   always_comb begin
      case (mode)
         PDIV_1:   tick_out = tick_in;
         PDIV_1P5: tick_out = tick_in && (phase != 2'd1);
         PDIV_2:   tick_out = tick_in && (phase == 2'd1);
         default:  tick_out = tick_in && (phase == 2'd2);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         phase <= 2'd0;
      else if (clear)
         phase <= 2'd0;
      else if (tick_in)
         phase <= (phase == prediv_last(mode)) ? 2'd0 : phase + 2'd1;
   end

endmodule

// File: rtl/acg_framediv.sv
module acg_framediv #(
   parameter int FRAME_LOG2 = 8,
   parameter int BIT_LOG2   = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic tick,
   input  logic speed,
   output logic lrck,
   output logic sclk
);

   localparam int FRAME_MSB = FRAME_LOG2 - 1;
   localparam int BIT_MSB   = BIT_LOG2 - 1;

   logic [FRAME_MSB:0] cnt, cnt_nxt;

   always_comb begin
      cnt_nxt = cnt + 1'b1;
      if (speed)
         cnt_nxt[FRAME_MSB] = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         lrck <= 1'b0;
         sclk <= 1'b0;
      end else if (clear) begin
         cnt  <= '0;
         lrck <= 1'b0;
         sclk <= 1'b0;
      end else if (tick) begin
         cnt  <= cnt_nxt;
         lrck <= speed ? cnt_nxt[FRAME_MSB-1] : cnt_nxt[FRAME_MSB];
         sclk <= speed ? cnt_nxt[BIT_MSB-1]   : cnt_nxt[BIT_MSB];
      end
   end

endmodule

// File: rtl/acg_port.sv
module acg_port
   import acg_pkg::*;
#(
   parameter int NUM_SRC    = 2,
   parameter int SEL_W      = 1,
   parameter int FRAME_LOG2 = 8,
   parameter int BIT_LOG2   = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               active,
   input  logic [NUM_SRC-1:0] src_tick,
   input  logic [SEL_W-1:0]   sel,
   input  prediv_e            freq,
   input  logic               speed,
   output logic               lrck,
   output logic               sclk,
   output logic               oe
);

   localparam int CFG_W = SEL_W + 3;

   logic [CFG_W-1:0] cfg_now, cfg_q;
   logic             clear, tick_sel, tick_int;

   assign cfg_now = {sel, freq, speed};
   assign clear   = !active || (cfg_now != cfg_q);

   always_comb begin
      tick_sel = 1'b0;
      for (int s = 0; s < NUM_SRC; s++)
         if (sel == SEL_W'(s))
            tick_sel = src_tick[s];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
         oe    <= 1'b0;
      end else begin
         cfg_q <= cfg_now;
         oe    <= active;
      end
   end

   acg_prediv i_prediv (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (clear),
      .tick_in  (tick_sel),
      .mode     (freq),
      .tick_out (tick_int)
   );

   acg_framediv #(
      .FRAME_LOG2 (FRAME_LOG2),
      .BIT_LOG2   (BIT_LOG2)
   ) i_framediv (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (clear),
      .tick  (tick_int),
      .speed (speed),
      .lrck  (lrck),
      .sclk  (sclk)
   );

endmodule

// File: rtl/audio_master_clkgen.sv
module audio_master_clkgen
   import acg_pkg::*;
#(
   parameter int NUM_SRC    = 2,
   parameter int NUM_PORTS  = 2,
   parameter int FRAME_LOG2 = 8,
   parameter int BIT_LOG2   = 2,
   parameter int SEL_W      = $clog2(NUM_SRC)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         master_en,
   input  logic [NUM_SRC-1:0]           src_tick,
   input  logic [NUM_PORTS-1:0]         port_master,
   input  logic [NUM_PORTS*SEL_W-1:0]   port_src_sel,
   input  logic [2*NUM_PORTS-1:0]       port_freq,
   input  logic [NUM_PORTS-1:0]         port_speed,
   output logic [NUM_PORTS-1:0]         lrck,
   output logic [NUM_PORTS-1:0]         sclk,
   output logic [NUM_PORTS-1:0]         clk_oe
);

   if (NUM_SRC < 2) begin : g_bad_src
      $error("NUM_SRC must be at least 2");
   end
   if (NUM_PORTS < 1) begin : g_bad_ports
      $error("NUM_PORTS must be at least 1");
   end
   if (BIT_LOG2 < 2) begin : g_bad_bit
      $error("BIT_LOG2 must be at least 2");
   end
   if (FRAME_LOG2 <= BIT_LOG2) begin : g_bad_frame
      $error("FRAME_LOG2 must exceed BIT_LOG2");
   end
   if (SEL_W != $clog2(NUM_SRC)) begin : g_bad_sel
      $error("SEL_W must match the source count");
   end

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      acg_port #(
         .NUM_SRC    (NUM_SRC),
         .SEL_W      (SEL_W),
         .FRAME_LOG2 (FRAME_LOG2),
         .BIT_LOG2   (BIT_LOG2)
      ) i_port (
         .clk      (clk),
         .rst_n    (rst_n),
         .active   (master_en && port_master[p]),
         .src_tick (src_tick),
         .sel      (port_src_sel[p*SEL_W +: SEL_W]),
         .freq     (prediv_e'(port_freq[2*p +: 2])),
         .speed    (port_speed[p]),
         .lrck     (lrck[p]),
         .sclk     (sclk[p]),
         .oe       (clk_oe[p])
      );
   end

endmodule

// File: rtl/audio_master_clkgen_chk.sv
module audio_master_clkgen_chk #(
   parameter int NUM_SRC   = 2,
   parameter int NUM_PORTS = 2,
   parameter int SEL_W     = $clog2(NUM_SRC)
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       master_en,
   input logic [NUM_SRC-1:0]         src_tick,
   input logic [NUM_PORTS-1:0]       port_master,
   input logic [NUM_PORTS*SEL_W-1:0] port_src_sel,
   input logic [2*NUM_PORTS-1:0]     port_freq,
   input logic [NUM_PORTS-1:0]       port_speed,
   input logic [NUM_PORTS-1:0]       lrck,
   input logic [NUM_PORTS-1:0]       sclk,
   input logic [NUM_PORTS-1:0]       clk_oe
);

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
      logic [SEL_W+2:0] cfg_now, cfg_d;
      logic             stable_d, tick_d, tick_now;

      assign cfg_now = {port_src_sel[p*SEL_W +: SEL_W], port_freq[2*p +: 2], port_speed[p]};

      always_comb begin
         tick_now = 1'b0;
         for (int s = 0; s < NUM_SRC; s++)
            if (port_src_sel[p*SEL_W +: SEL_W] == SEL_W'(s))
               tick_now = src_tick[s];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cfg_d    <= '0;
            stable_d <= 1'b0;
            tick_d   <= 1'b0;
         end else begin
            cfg_d    <= cfg_now;
            stable_d <= master_en && port_master[p] && (cfg_now == cfg_d);
            tick_d   <= tick_now;
         end
      end

      // R5: idle port keeps its clocks low
      a_r5_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
         !clk_oe[p] |-> (!lrck[p] && !sclk[p]));

      // R6: clock edges only follow a tick of the selected source
      a_r6_edge_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
         (stable_d && ((sclk[p] != $past(sclk[p])) || (lrck[p] != $past(lrck[p])))) |-> tick_d);

      // R7: frame clock moves only with a falling bit clock
      a_r7_lrck_on_sclk_fall: assert property (@(posedge clk) disable iff (!rst_n)
         (stable_d && (lrck[p] != $past(lrck[p]))) |-> ($past(sclk[p]) && !sclk[p]));

      // R8: reconfiguration or disable leaves both clocks low
      a_r8_restart_low: assert property (@(posedge clk) disable iff (!rst_n)
         !stable_d |-> (!lrck[p] && !sclk[p]));
   end

endmodule

bind audio_master_clkgen audio_master_clkgen_chk #(
   .NUM_SRC   (NUM_SRC),
   .NUM_PORTS (NUM_PORTS),
   .SEL_W     (SEL_W)
) i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .master_en    (master_en),
   .src_tick     (src_tick),
   .port_master  (port_master),
   .port_src_sel (port_src_sel),
   .port_freq    (port_freq),
   .port_speed   (port_speed),
   .lrck         (lrck),
   .sclk         (sclk),
   .clk_oe       (clk_oe)
);

// File: tb/test_audio_master_clkgen.sv
module test_audio_master_clkgen;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       master_en = 1'b0;
   logic [1:0] src_tick;
   logic [1:0] port_master = 2'b00;
   logic [1:0] port_src_sel = 2'b00;
   logic [3:0] port_freq = 4'h0;
   logic [1:0] port_speed = 2'b00;
   logic [1:0] lrck, sclk, clk_oe;

   int   n_run = 0, n_fail = 0;
   int   src_per [2];
   int   src_cnt [2];
   logic [1:0] src_run = 2'b11;

   always #10 clk = ~clk;

   audio_master_clkgen i_audio_master_clkgen (
      .clk          (clk),
      .rst_n        (rst_n),
      .master_en    (master_en),
      .src_tick     (src_tick),
      .port_master  (port_master),
      .port_src_sel (port_src_sel),
      .port_freq    (port_freq),
      .port_speed   (port_speed),
      .lrck         (lrck),
      .sclk         (sclk),
      .clk_oe       (clk_oe)
   );

   // periodic one-cycle source ticks, driven away from the active edge
   initial begin
      src_tick = 2'b00;
      src_cnt[0] = 0;
      src_cnt[1] = 0;
      forever begin
         @(negedge clk);
         for (int s = 0; s < 2; s++) begin
            src_tick[s] = src_run[s] && (src_cnt[s] == 0);
            src_cnt[s] = (src_cnt[s] + 1 >= src_per[s]) ? 0 : src_cnt[s] + 1;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int pre_num(input int code); // twice the pre-divide ratio
      case (code)
         0: return 2;
         1: return 3;
         2: return 4;
         default: return 6;
      endcase
   endfunction

   function automatic int exp_lr(input int per, input int code, input int spd);
      return per * pre_num(code) * (spd ? 128 : 256) / 2;
   endfunction

   function automatic int exp_sc(input int per, input int code, input int spd);
      return per * pre_num(code) * (spd ? 2 : 4) / 2;
   endfunction

   task automatic measure(input int p, input int lr_e, input int sc_e, input string tag);
      int   guard = 0, cyc = 0, hi = 1, rises = 0, r1 = -1, r2 = -1;
      logic pl, ps;
      pl = lrck[p];
      forever begin
         @(negedge clk);
         guard++;
         if ((!pl && lrck[p]) || guard > 20000) break;
         pl = lrck[p];
      end
      ps = sclk[p];
      pl = lrck[p];
      forever begin
         @(negedge clk);
         cyc++;
         if ((!pl && lrck[p]) || cyc > 20000) break;
         if (lrck[p]) hi++;
         if (!ps && sclk[p]) begin
            rises++;
            if (r1 < 0) r1 = cyc; else if (r2 < 0) r2 = cyc;
         end
         ps = sclk[p];
         pl = lrck[p];
      end
      chk(cyc == lr_e, "R1 R2", {tag, " lrck period"}, cyc, lr_e);
      chk(r2 - r1 == sc_e, "R3", {tag, " sclk period"}, r2 - r1, sc_e);
      chk(rises == 64, "R3", {tag, " sclk per frame"}, rises, 64);
      chk(hi == lr_e / 2, "R7", {tag, " lrck high time"}, hi, lr_e / 2);
   endtask

   initial begin
      #3000000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      src_per[0] = 1 + ($urandom % 3);
      src_per[1] = (src_per[0] % 3) + 1;
      repeat (4) @(negedge clk);
      // R9: reset state
      chk(lrck == 2'b00 && sclk == 2'b00 && clk_oe == 2'b00, "R9", "reset outputs",
          {lrck, sclk, clk_oe}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      master_en = 1'b1;
      port_master = 2'b11;
      @(negedge clk);
      @(negedge clk);
      chk(clk_oe == 2'b11, "R5", "oe with master", clk_oe, 3);

      // R1 R2 R3 R4 R7: every code and speed on each port, other port randomized
      for (int p = 0; p < 2; p++) begin
         for (int code = 0; code < 4; code++) begin
            for (int spd = 0; spd < 2; spd++) begin
               int sel, q;
               q = 1 - p;
               sel = $urandom % 2;
               port_src_sel[p] = sel[0];
               port_freq[2*p +: 2] = code[1:0];
               port_speed[p] = spd[0];
               port_src_sel[q] = 1'($urandom);
               port_freq[2*q +: 2] = 2'($urandom);
               port_speed[q] = 1'($urandom);
               measure(p, exp_lr(src_per[sel], code, spd), exp_sc(src_per[sel], code, spd),
                       $sformatf("R4 port%0d src%0d code%0d spd%0d", p, sel, code, spd));
            end
         end
      end

      // R8: setting change mid-frame restarts both clocks low
      port_freq = 4'h0; port_speed = 2'b00; port_src_sel = 2'b00;
      repeat (300) @(negedge clk);
      port_freq[1:0] = 2'b10;
      @(negedge clk);
      chk(lrck[0] == 1'b0 && sclk[0] == 1'b0, "R8", "restart low after freq change",
          {lrck[0], sclk[0]}, 0);
      repeat (500) @(negedge clk);
      port_speed[0] = 1'b1;
      @(negedge clk);
      chk(lrck[0] == 1'b0 && sclk[0] == 1'b0, "R8", "restart low after speed change",
          {lrck[0], sclk[0]}, 0);
      measure(0, exp_lr(src_per[0], 2, 1), exp_sc(src_per[0], 2, 1), "R8 after restart");

      // R6: no source ticks -> clocks frozen
      repeat (37) @(negedge clk);
      src_run = 2'b00;
      @(negedge clk);
      @(negedge clk);
      begin
         logic [3:0] snap;
         int changes = 0;
         snap = {lrck, sclk};
         repeat (60) begin
            @(negedge clk);
            if ({lrck, sclk} != snap) changes++;
         end
         chk(changes == 0, "R6", "clocks frozen without ticks", changes, 0);
      end
      src_run = 2'b11;

      // R5: master bit off for port 1, global enable off
      port_master[1] = 1'b0;
      @(negedge clk);
      begin
         int bad = 0;
         repeat (100) begin
            @(negedge clk);
            if (clk_oe[1] || lrck[1] || sclk[1]) bad++;
         end
         chk(bad == 0, "R5", "port1 idle and low", bad, 0);
      end
      chk(clk_oe[0] == 1'b1, "R5", "port0 still driven", clk_oe[0], 1);
      master_en = 1'b0;
      @(negedge clk);
      chk(clk_oe == 2'b00 && lrck == 2'b00 && sclk == 2'b00, "R5", "global disable",
          {clk_oe, lrck, sclk}, 0);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule